// File: doc/BRIEF.md
# Pin Resistance Scan Sequencer

This block drives a repeating survey of the resistance to ground on five connector pins. While its enable input is high it walks the pins in a fixed order. For each pin it opens that pin's signal switch, asks an external analog measurement unit for a reading, and waits for the done strobe. It then stores the returned code in that pin's result slot and closes the switch again.

Each stored code is compared with a programmed threshold. A code strictly below the threshold gives a one-cycle interrupt pulse. After the fifth pin the block either halts or waits a selectable number of 1 ms ticks and starts the next pass. The ticks come from a timebase outside the block. The measurement itself happens outside the block.

Top module: `rscan_top`

## Requirements
- R1: After reset, meas_req, sw_off and irq are low and all five result slots read zero.
- R2: While scan_en is low no measurement is requested, and a meas_done pulse changes no result slot and raises no irq.
- R3: A pass measures the pins in index order 0, 1, 2, 3, 4 on meas_pin (0 and 1 are the two sideband pins, 2 the configuration-channel pin, 3 the right/D+ pin, 4 the left/D- pin). The first request follows one cycle after scan_en rises.
- R4: Throughout a request, sw_off has exactly bit meas_pin set; otherwise sw_off is all zero.
- R5: The clock edge that samples meas_done during a request drops meas_req and clears sw_off. The next pin's request comes one cycle later.
- R6: On the edge that samples meas_done, meas_code is written into result slot meas_pin. res_flat bits [8*i+7:8*i] hold slot i.
- R7: irq is high for exactly the one cycle after a sampled meas_done whose code is strictly below thresh. A code equal to or above thresh gives no pulse.
- R8: With ivl_sel = 0 the block halts after pin 4 and issues no further request until scan_en is cleared and set again.
- R9: With ivl_sel = 1, 2 or 3 the next pass starts on the edge that samples the 100th, 1000th or 10000th tick_ms pulse after the pin-4 done edge. Ticks on that done edge itself are not counted.
- R10: Clearing scan_en drops meas_req and sw_off on the next edge. A later meas_done is ignored. Setting scan_en again restarts at pin 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_en | input | 1 | Scan enable; low aborts and idles |
| thresh | input | 8 | Interrupt threshold code |
| ivl_sel | input | 2 | 0 one pass, 1/2/3 = 100/1000/10000 ticks between passes |
| tick_ms | input | 1 | 1 ms timebase pulse |
| meas_done | input | 1 | Measurement complete strobe |
| meas_code | input | 8 | Resistance code returned with meas_done |
| meas_req | output | 1 | Measurement request, held until done |
| meas_pin | output | 3 | Index of the pin under test |
| sw_off | output | 5 | Per-pin switch-disable, one-hot during a request |
| irq | output | 1 | One-cycle low-resistance interrupt |
| res_flat | output | 40 | Five 8-bit result slots, slot i at bits [8i+7:8i] |

## Verification
The result slot, sw_off release and irq all change on the edge that samples meas_done. They are checked at the falling edge that follows that edge. The irq is checked again one falling edge later to confirm it lasts a single cycle. The next request appears one edge after that, and the bench waits for it by polling before it checks meas_pin and sw_off. For the interval, the bench counts tick_ms values at each rising edge after the done edge, and requires the request to appear exactly at the edge of the Nth tick.

// File: rtl/rscan_pkg.sv
package rscan_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_MEAS,
      ST_GAP,
      ST_WAIT,
      ST_HALT
   } scan_state_t;

   localparam logic [1:0] IVL_ONCE = 2'd0;
endpackage

// File: rtl/rscan_interval.sv
module rscan_interval #(
   parameter int TICKS_SHORT = 100,
   parameter int TICKS_MID   = 1000,
   parameter int TICKS_LONG  = 10000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       run,
   input  logic       tick,
   input  logic [1:0] sel,
   output logic       expire
);
   localparam int CNT_W = $clog2(TICKS_LONG + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   always_comb begin
      case (sel)
         2'd1:    limit = CNT_W'(TICKS_SHORT);
         2'd2:    limit = CNT_W'(TICKS_MID);
         default: limit = CNT_W'(TICKS_LONG);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start)          cnt_q <= '0;
      else if (run && tick)    cnt_q <= cnt_q + CNT_W'(1);
   end

   assign expire = run && tick && (cnt_q == limit - CNT_W'(1));

   assert_hold_without_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick && !start) |=> $stable(cnt_q));
   assert_clear_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt_q == '0));
endmodule

// File: rtl/rscan_ctrl.sv
module rscan_ctrl
   import rscan_pkg::*;
#(
   parameter int NUM_PINS = 5,
   parameter int PIN_W    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scan_en,
   input  logic                meas_done,
   input  logic [1:0]          ivl_sel,
   input  logic                expire,
   output logic                meas_req,
   output logic [PIN_W-1:0]    meas_pin,
   output logic [NUM_PINS-1:0] sw_off,
   output logic                wr_en,
   output logic                ivl_start,
   output logic                ivl_run
);
   localparam logic [PIN_W-1:0] LAST_PIN = PIN_W'(NUM_PINS - 1);

   scan_state_t      state_q;
   logic [PIN_W-1:0] pin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pin_q   <= '0;
      end else if (!scan_en) begin
         state_q <= ST_IDLE;
         pin_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               state_q <= ST_MEAS;
               pin_q   <= '0;
            end
            ST_MEAS: begin
               if (meas_done) begin
                  if (pin_q == LAST_PIN) begin
                     state_q <= (ivl_sel == IVL_ONCE) ? ST_HALT : ST_WAIT;
                  end else begin
                     pin_q   <= pin_q + PIN_W'(1);
                     state_q <= ST_GAP;
                  end
               end
            end
            ST_GAP:  state_q <= ST_MEAS;
            ST_WAIT: begin
               if (expire) begin
                  pin_q   <= '0;
                  state_q <= ST_MEAS;
               end
            end
            ST_HALT: state_q <= ST_HALT;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign meas_req  = (state_q == ST_MEAS);
   assign meas_pin  = pin_q;
   assign wr_en     = meas_req && meas_done;
   assign ivl_start = wr_en && (pin_q == LAST_PIN);
   assign ivl_run   = (state_q == ST_WAIT);

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_sw
      assign sw_off[i] = meas_req && (pin_q == PIN_W'(i));
   end

   assert_single_switch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sw_off));
   assert_pin_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      meas_req |-> (meas_pin <= LAST_PIN));
   assert_release_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_req && meas_done) |=> (!meas_req && sw_off == '0));
   assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_en |=> (!meas_req && sw_off == '0));
endmodule

// File: rtl/rscan_results.sv
module rscan_results #(
   parameter int NUM_PINS = 5,
   parameter int PIN_W    = 3,
   parameter int CODE_W   = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [PIN_W-1:0]           wr_pin,
   input  logic [CODE_W-1:0]          code,
   input  logic [CODE_W-1:0]          thresh,
   output logic [NUM_PINS*CODE_W-1:0] res_flat,
   output logic                       irq
);
   logic below;
   assign below = (code < thresh);

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_slot
      logic [CODE_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 slot_q <= '0;
         else if (wr_en && wr_pin == PIN_W'(i))      slot_q <= code;
      end
      assign res_flat[i*CODE_W +: CODE_W] = slot_q;

      assert_slot_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_pin == PIN_W'(i)) |=> (slot_q == $past(code)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= wr_en && below;
   end

   assert_irq_on_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && code < thresh) |=> irq);
   assert_irq_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !irq);
endmodule

// File: rtl/rscan_top.sv
module rscan_top #(
   parameter int NUM_PINS    = 5,
   parameter int CODE_W      = 8,
   parameter int TICKS_SHORT = 100,
   parameter int TICKS_MID   = 1000,
   parameter int TICKS_LONG  = 10000
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       scan_en,
   input  logic [CODE_W-1:0]          thresh,
   input  logic [1:0]                 ivl_sel,
   input  logic                       tick_ms,
   input  logic                       meas_done,
   input  logic [CODE_W-1:0]          meas_code,
   output logic                       meas_req,
   output logic [$clog2(NUM_PINS)-1:0] meas_pin,
   output logic [NUM_PINS-1:0]        sw_off,
   output logic                       irq,
   output logic [NUM_PINS*CODE_W-1:0] res_flat
);
   localparam int PIN_W = $clog2(NUM_PINS);

   if (NUM_PINS < 2) begin : g_bad_pins
      $error("rscan_top: NUM_PINS must be at least 2");
   end
   if (CODE_W < 1) begin : g_bad_code
      $error("rscan_top: CODE_W must be positive");
   end
   if (TICKS_SHORT < 2 || TICKS_MID < TICKS_SHORT || TICKS_LONG < TICKS_MID) begin : g_bad_ticks
      $error("rscan_top: interval tick counts must be ascending and at least 2");
   end

   logic wr_en;
   logic ivl_start;
   logic ivl_run;
   logic expire;

   rscan_ctrl #(
      .NUM_PINS (NUM_PINS),
      .PIN_W    (PIN_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .scan_en   (scan_en),
      .meas_done (meas_done),
      .ivl_sel   (ivl_sel),
      .expire    (expire),
      .meas_req  (meas_req),
      .meas_pin  (meas_pin),
      .sw_off    (sw_off),
      .wr_en     (wr_en),
      .ivl_start (ivl_start),
      .ivl_run   (ivl_run)
   );

   rscan_interval #(
      .TICKS_SHORT (TICKS_SHORT),
      .TICKS_MID   (TICKS_MID),
      .TICKS_LONG  (TICKS_LONG)
   ) u_ivl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (ivl_start),
      .run    (ivl_run),
      .tick   (tick_ms),
      .sel    (ivl_sel),
      .expire (expire)
   );

   rscan_results #(
      .NUM_PINS (NUM_PINS),
      .PIN_W    (PIN_W),
      .CODE_W   (CODE_W)
   ) u_res (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_pin   (meas_pin),
      .code     (meas_code),
      .thresh   (thresh),
      .res_flat (res_flat),
      .irq      (irq)
   );

   assert_halt_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ivl_start && ivl_sel == 2'd0 && scan_en) |=> !meas_req);
endmodule

// File: tb/sim_rscan_top.sv
module sim_rscan_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scan_en = 1'b0;
   logic [7:0]  thresh = 8'd0;
   logic [1:0]  ivl_sel = 2'd0;
   logic        tick_ms = 1'b0;
   logic        meas_done = 1'b0;
   logic [7:0]  meas_code = 8'd0;
   logic        meas_req;
   logic [2:0]  meas_pin;
   logic [4:0]  sw_off;
   logic        irq;
   logic [39:0] res_flat;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   bit sparse_tick = 1'b0;
   logic [7:0] exp_res [5];
   logic [7:0] plan [5];

   always #5 clk = ~clk;

   rscan_top u0 (
      .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .thresh(thresh),
      .ivl_sel(ivl_sel), .tick_ms(tick_ms), .meas_done(meas_done),
      .meas_code(meas_code), .meas_req(meas_req), .meas_pin(meas_pin),
      .sw_off(sw_off), .irq(irq), .res_flat(res_flat)
   );

   always @(negedge clk) tick_ms <= sparse_tick ? 1'($urandom_range(0, 1)) : 1'b1;

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 190000) begin
         fails = fails + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
         finish_run();
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] slot(input int i);
      return res_flat[i*8 +: 8];
   endfunction

   function automatic logic exp_irq(input logic [7:0] c, input logic [7:0] t);
      return c < t;
   endfunction

   task automatic wait_req();
      for (int k = 0; k < 30000; k++) begin
         if (meas_req) return;
         @(negedge clk);
      end
   endtask

   // One full pass; returns at the negedge just after the pin-4 done edge
   task automatic do_pass();
      for (int p = 0; p < 5; p++) begin
         wait_req();
         check(meas_req === 1'b1, "R3 request present", 32'(meas_req), 1);
         check(meas_pin === 3'(p), "R3 pin order", 32'(meas_pin), p);
         check(sw_off === 5'(1 << p), "R4 switch open on pin", 32'(sw_off), 32'(1 << p));
         for (int d = 0; d < int'($urandom_range(0, 2)); d++) begin
            @(negedge clk);
            check(sw_off === 5'(1 << p), "R4 switch held open", 32'(sw_off), 32'(1 << p));
         end
         meas_done = 1'b1;
         meas_code = plan[p];
         exp_res[p] = plan[p];
         @(negedge clk);
         meas_done = 1'b0;
         check(sw_off === 5'd0, "R5 switch closed after done", 32'(sw_off), 0);
         check(meas_req === 1'b0, "R5 request dropped", 32'(meas_req), 0);
         check(slot(p) === exp_res[p], "R6 result stored", 32'(slot(p)), 32'(exp_res[p]));
         check(irq === exp_irq(plan[p], thresh), "R7 irq level", 32'(irq), 32'(exp_irq(plan[p], thresh)));
         if (p < 4) begin
            @(negedge clk);
            check(irq === 1'b0, "R7 irq one cycle", 32'(irq), 0);
            check(meas_req === 1'b1 && meas_pin === 3'(p + 1), "R5 next request after one gap",
                  32'({meas_req, meas_pin}), 32'({1'b1, 3'(p + 1)}));
         end
      end
   endtask

   task automatic check_interval(input int n);
      int seen = 0;
      for (int k = 0; k < 30000; k++) begin
         @(posedge clk);
         if (tick_ms) seen++;
         @(negedge clk);
         if (meas_req) break;
      end
      check(meas_req === 1'b1 && seen == n, "R9 interval ticks", 32'(seen), 32'(n));
      check(meas_pin === 3'd0, "R9 restart at pin 0", 32'(meas_pin), 0);
   endtask

   task automatic random_plan();
      for (int p = 0; p < 5; p++) plan[p] = 8'($urandom_range(0, 255));
   endtask

   initial begin
      void'($urandom(32'h1f2e3d4c));
      for (int p = 0; p < 5; p++) exp_res[p] = 8'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(meas_req === 1'b0 && sw_off === 5'd0, "R1 idle outputs", 32'({meas_req, sw_off}), 0);
      check(irq === 1'b0, "R1 irq low", 32'(irq), 0);
      check(res_flat === 40'd0, "R1 results zero", res_flat[31:0], 0);

      // R2 disabled: done ignored
      thresh = 8'hff;
      meas_done = 1'b1;
      meas_code = 8'h12;
      @(negedge clk);
      meas_done = 1'b0;
      check(res_flat === 40'd0, "R2 done ignored while disabled", res_flat[31:0], 0);
      check(irq === 1'b0, "R2 no irq while disabled", 32'(irq), 0);
      repeat (5) @(negedge clk);
      check(meas_req === 1'b0, "R2 no request while disabled", 32'(meas_req), 0);

      // R8 one pass, random codes
      ivl_sel = 2'd0;
      thresh = 8'($urandom_range(1, 255));
      random_plan();
      scan_en = 1'b1;
      @(negedge clk);
      check(meas_req === 1'b1 && meas_pin === 3'd0, "R3 first request one cycle after enable",
            32'({meas_req, meas_pin}), 32'({1'b1, 3'd0}));
      do_pass();
      begin
         int extra = 0;
         for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (meas_req) extra++;
         end
         check(extra == 0, "R8 halted after one pass", 32'(extra), 0);
      end
      scan_en = 1'b0;
      @(negedge clk);

      // R7 threshold boundary
      thresh = 8'd100;
      plan[0] = 8'd100; plan[1] = 8'd99; plan[2] = 8'd255; plan[3] = 8'd0; plan[4] = 8'd101;
      scan_en = 1'b1;
      do_pass();
      scan_en = 1'b0;
      @(negedge clk);

      // R9 periodic passes
      ivl_sel = 2'd1;
      sparse_tick = 1'b1;
      thresh = 8'($urandom_range(0, 255));
      random_plan();
      scan_en = 1'b1;
      do_pass();
      check_interval(100);
      random_plan();
      do_pass();
      ivl_sel = 2'd2;
      check_interval(1000);
      random_plan();
      sparse_tick = 1'b0;
      do_pass();
      ivl_sel = 2'd3;
      check_interval(10000);

      // R10 abort mid scan
      plan[0] = 8'h33;
      meas_done = 1'b1;
      meas_code = plan[0];
      exp_res[0] = plan[0];
      @(negedge clk);
      meas_done = 1'b0;
      wait_req();
      check(meas_pin === 3'd1, "R10 setup at pin 1", 32'(meas_pin), 1);
      scan_en = 1'b0;
      @(negedge clk);
      check(meas_req === 1'b0 && sw_off === 5'd0, "R10 abort releases", 32'({meas_req, sw_off}), 0);
      meas_done = 1'b1;
      meas_code = 8'h00;
      thresh = 8'hff;
      @(negedge clk);
      meas_done = 1'b0;
      check(slot(1) === exp_res[1], "R10 late done ignored", 32'(slot(1)), 32'(exp_res[1]));
      check(irq === 1'b0, "R10 no irq after abort", 32'(irq), 0);
      scan_en = 1'b1;
      @(negedge clk);
      check(meas_req === 1'b1 && meas_pin === 3'd0, "R10 restart at pin 0",
            32'({meas_req, meas_pin}), 32'({1'b1, 3'd0}));
      scan_en = 1'b0;
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule